// File: doc/BRIEF.md
# Rectangle Copy Blit Engine

The engine moves a rectangle of pixels from one place to another inside a byte-addressed frame memory. Software presents the source and destination corner coordinates, the rectangle size, the row pitches, the base offsets, a pixel-format code, a raster-operation code and two direction flags, then pulses a start input. The engine checks the request, walks the rectangle row by row and issues single-pixel read and write transfers on a valid/ready memory port. It pulses a completion strobe and, for a finished copy, hands back the new destination coordinates for software to store.

When a direction flag is clear, the programmed coordinate on that axis names the far edge (rightmost column or bottom row) rather than the near one. In that case the engine gathers the whole source rectangle into a local staging store before it writes anything, so source and destination may overlap freely. With both flags set it reads and writes each pixel in turn, which keeps rectangles unbounded in area but assumes the regions do not overlap in a harmful way.

Requests that are malformed end with the completion strobe and an error flag, and no write reaches memory.

Top module: `blit_copy_engine`

## Requirements
- R1: The format code `fmt_i` selects bytes per pixel: 2 gives 1, 3 and 4 give 2, 5 gives 3, 6 gives 4. Every transfer carries that byte count on `mem_size_o` (write data and read data are little-endian in the low bytes). Any other code ends the request with `err_o` and no write.
- R2: Only `rop_i` equal to 0xCC copies. Any other value ends with `done_o`, no error, no memory transfer and no coordinate hand-back.
- R3: With `x_fwd_i` low, the leftmost column used is x + 1 − width; with `y_fwd_i` low, the top row used is y + 1 − height. The correction applies to source and destination alike.
- R4: A pixel at column c, row r is at offset + r·pitch + c·bytes. With `sep_i` high the source and destination each use their own pitch and offset; with it low both use `def_pitch_i` and `def_off_i`.
- R5: A corrected source or destination coordinate above 0x3FFF (including a wrap below zero) ends with `err_o` and no write.
- R6: If the byte just after the last pixel of the last row of either rectangle lies beyond `MEM_BYTES`, the request ends with `err_o` and no write; ending exactly at `MEM_BYTES` is legal.
- R7: A zero source pitch or a zero destination pitch (as selected by R4) ends with `err_o` and no write.
- R8: With either direction flag low, every source read happens before the first write and the result equals a copy taken from a snapshot of the source; such a request whose area exceeds `BUF_PIX` ends with `err_o` and no write.
- R9: After a successful copy, `wb_valid_o` pulses with `done_o`; `dst_x_wb_o` is the corrected destination x plus width when `x_fwd_i` is high and the corrected x otherwise; `dst_y_wb_o` follows the same rule with height and `y_fwd_i`.
- R10: `done_o` is a one-cycle pulse ending every accepted request; `err_o` is high only together with `done_o`; `start_i` has no effect while a request is running or in its `done_o` cycle.
- R11: A request held on the memory port without `mem_ready_i` keeps its address, direction and write data unchanged.
- R12: A zero width or zero height ends with `done_o`, no error, no memory transfer and no hand-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a request (taken only when idle) |
| fmt_i | input | 4 | Pixel format code |
| rop_i | input | 8 | Raster-operation code |
| x_fwd_i | input | 1 | 1: x names the left edge; 0: the right edge |
| y_fwd_i | input | 1 | 1: y names the top edge; 0: the bottom edge |
| sep_i | input | 1 | 1: separate source/destination pitch and offset |
| src_x_i | input | 16 | Source x |
| src_y_i | input | 16 | Source y |
| dst_x_i | input | 16 | Destination x |
| dst_y_i | input | 16 | Destination y |
| width_i | input | 16 | Rectangle width in pixels |
| height_i | input | 16 | Rectangle height in rows |
| src_pitch_i | input | 16 | Source row pitch in bytes |
| dst_pitch_i | input | 16 | Destination row pitch in bytes |
| def_pitch_i | input | 16 | Shared row pitch in bytes |
| src_off_i | input | ADDR_W | Source base offset |
| dst_off_i | input | ADDR_W | Destination base offset |
| def_off_i | input | ADDR_W | Shared base offset |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | 1: write, 0: read |
| mem_addr_o | output | ADDR_W | Byte address of the pixel |
| mem_size_o | output | 3 | Bytes in the transfer |
| mem_wdata_o | output | 32 | Write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Request rejected (with done_o) |
| wb_valid_o | output | 1 | Coordinate hand-back valid |
| dst_x_wb_o | output | 16 | New destination x |
| dst_y_wb_o | output | 16 | New destination y |

## Verification
The completion cycle and a fresh start request can coincide: the bench keeps `start_i` high through the whole copy including the `done_o` cycle, and in another run pulses it again mid-copy. It judges the result by counting exactly one `done_o` and seeing no further memory traffic in the cycles that follow. Each copy is also compared against an arithmetic model over the full memory, under a memory that withholds `mem_ready_i` on a pseudo-random pattern.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_FIN
  } blit_st_e;

  localparam logic [7:0] ROP_SRC_COPY = 8'hCC;

  function automatic logic [2:0] fmt_bytes(input logic [3:0] code);
    case (code)
      4'd2:       return 3'd1;
      4'd3, 4'd4: return 3'd2;
      4'd5:       return 3'd3;
      4'd6:       return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/blit_setup.sv
module blit_setup import blit_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 65536,
  parameter int BUF_PIX   = 64
) (
  input  logic [3:0]        fmt_i,
  input  logic [7:0]        rop_i,
  input  logic              x_fwd_i,
  input  logic              y_fwd_i,
  input  logic              sep_i,
  input  logic [15:0]       src_x_i,
  input  logic [15:0]       src_y_i,
  input  logic [15:0]       dst_x_i,
  input  logic [15:0]       dst_y_i,
  input  logic [15:0]       width_i,
  input  logic [15:0]       height_i,
  input  logic [15:0]       src_pitch_i,
  input  logic [15:0]       dst_pitch_i,
  input  logic [15:0]       def_pitch_i,
  input  logic [ADDR_W-1:0] src_off_i,
  input  logic [ADDR_W-1:0] dst_off_i,
  input  logic [ADDR_W-1:0] def_off_i,
  output logic [2:0]        nbytes_o,
  output logic              is_copy_o,
  output logic              is_empty_o,
  output logic              bad_o,
  output logic              staged_o,
  output logic [ADDR_W-1:0] src_base_o,
  output logic [ADDR_W-1:0] dst_base_o,
  output logic [15:0]       src_pitch_o,
  output logic [15:0]       dst_pitch_o,
  output logic [15:0]       wb_x_o,
  output logic [15:0]       wb_y_o
);
  localparam int WW = ADDR_W + 40;

  function automatic logic [17:0] edge_fix(input logic [15:0] v, input logic [15:0] n,
                                           input logic fwd);
    return fwd ? {2'b00, v} : ({2'b00, v} + 18'd1 - {2'b00, n});
  endfunction

  logic [17:0]       csx, csy, cdx, cdy;
  logic [ADDR_W-1:0] so, dso;
  logic [WW-1:0]     base_s, base_d, tail_s, tail_d;
  logic [31:0]       area;
  logic              coord_bad, bound_bad, buf_bad;

  assign csx = edge_fix(src_x_i, width_i, x_fwd_i);
  assign cdx = edge_fix(dst_x_i, width_i, x_fwd_i);
  assign csy = edge_fix(src_y_i, height_i, y_fwd_i);
  assign cdy = edge_fix(dst_y_i, height_i, y_fwd_i);

  assign nbytes_o    = fmt_bytes(fmt_i);
  assign src_pitch_o = sep_i ? src_pitch_i : def_pitch_i;
  assign dst_pitch_o = sep_i ? dst_pitch_i : def_pitch_i;
  assign so          = sep_i ? src_off_i : def_off_i;
  assign dso         = sep_i ? dst_off_i : def_off_i;

  assign base_s = WW'(so) + WW'(csy) * WW'(src_pitch_o) + WW'(csx) * WW'(nbytes_o);
  assign base_d = WW'(dso) + WW'(cdy) * WW'(dst_pitch_o) + WW'(cdx) * WW'(nbytes_o);
  assign tail_s = base_s + (WW'(height_i) - WW'(1)) * WW'(src_pitch_o)
                + WW'(width_i) * WW'(nbytes_o);
  assign tail_d = base_d + (WW'(height_i) - WW'(1)) * WW'(dst_pitch_o)
                + WW'(width_i) * WW'(nbytes_o);

  assign coord_bad = |{csx[17:14], csy[17:14], cdx[17:14], cdy[17:14]};
  assign bound_bad = (tail_s > WW'(MEM_BYTES)) || (tail_d > WW'(MEM_BYTES));
  assign area      = 32'(width_i) * 32'(height_i);
  assign staged_o  = !x_fwd_i || !y_fwd_i;
  assign buf_bad   = staged_o && (area > 32'(BUF_PIX));

  assign is_copy_o  = (rop_i == ROP_SRC_COPY);
  assign is_empty_o = (width_i == 16'd0) || (height_i == 16'd0);
  assign bad_o      = (nbytes_o == 3'd0) || (src_pitch_o == 16'd0) || (dst_pitch_o == 16'd0)
                    || coord_bad || bound_bad || buf_bad;

  assign src_base_o = base_s[ADDR_W-1:0];
  assign dst_base_o = base_d[ADDR_W-1:0];
  assign wb_x_o     = x_fwd_i ? (cdx[15:0] + width_i) : cdx[15:0];
  assign wb_y_o     = y_fwd_i ? (cdy[15:0] + height_i) : cdy[15:0];
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rewind_i,
  input  logic              step_i,
  input  logic [15:0]       width_i,
  input  logic [15:0]       height_i,
  input  logic [2:0]        nbytes_i,
  input  logic [15:0]       src_pitch_i,
  input  logic [15:0]       dst_pitch_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              last_o
);
  logic [15:0]       cx_q, cy_q;
  logic [ADDR_W-1:0] col_q, srow_q, drow_q, sbase_q, dbase_q;
  logic [15:0]       sp_q, dp_q;
  logic              row_end;

  assign row_end    = (cx_q == width_i - 16'd1);
  assign last_o     = row_end && (cy_q == height_i - 16'd1);
  assign src_addr_o = srow_q + col_q;
  assign dst_addr_o = drow_q + col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cx_q    <= '0;
      cy_q    <= '0;
      col_q   <= '0;
      srow_q  <= '0;
      drow_q  <= '0;
      sbase_q <= '0;
      dbase_q <= '0;
      sp_q    <= '0;
      dp_q    <= '0;
      idx_o   <= '0;
    end else if (load_i) begin
      cx_q    <= '0;
      cy_q    <= '0;
      col_q   <= '0;
      idx_o   <= '0;
      srow_q  <= src_base_i;
      drow_q  <= dst_base_i;
      sbase_q <= src_base_i;
      dbase_q <= dst_base_i;
      sp_q    <= src_pitch_i;
      dp_q    <= dst_pitch_i;
    end else if (rewind_i) begin
      cx_q   <= '0;
      cy_q   <= '0;
      col_q  <= '0;
      idx_o  <= '0;
      srow_q <= sbase_q;
      drow_q <= dbase_q;
    end else if (step_i) begin
      idx_o <= idx_o + IDX_W'(1);
      if (row_end) begin
        cx_q   <= '0;
        cy_q   <= cy_q + 16'd1;
        col_q  <= '0;
        srow_q <= srow_q + ADDR_W'(sp_q);
        drow_q <= drow_q + ADDR_W'(dp_q);
      end else begin
        cx_q  <= cx_q + 16'd1;
        col_q <= col_q + ADDR_W'(nbytes_i);
      end
    end
  end
endmodule

// File: rtl/blit_stage_buf.sv
module blit_stage_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) store_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = store_q[raddr_i];
endmodule

// File: rtl/blit_copy_engine.sv
module blit_copy_engine import blit_pkg::*; #(
  parameter int MEM_BYTES = 65536,
  parameter int BUF_PIX   = 64,
  localparam int ADDR_W   = $clog2(MEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        fmt_i,
  input  logic [7:0]        rop_i,
  input  logic              x_fwd_i,
  input  logic              y_fwd_i,
  input  logic              sep_i,
  input  logic [15:0]       src_x_i,
  input  logic [15:0]       src_y_i,
  input  logic [15:0]       dst_x_i,
  input  logic [15:0]       dst_y_i,
  input  logic [15:0]       width_i,
  input  logic [15:0]       height_i,
  input  logic [15:0]       src_pitch_i,
  input  logic [15:0]       dst_pitch_i,
  input  logic [15:0]       def_pitch_i,
  input  logic [ADDR_W-1:0] src_off_i,
  input  logic [ADDR_W-1:0] dst_off_i,
  input  logic [ADDR_W-1:0] def_off_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [2:0]        mem_size_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              wb_valid_o,
  output logic [15:0]       dst_x_wb_o,
  output logic [15:0]       dst_y_wb_o
);
  localparam int IDX_W = (BUF_PIX > 1) ? $clog2(BUF_PIX) : 1;

  blit_st_e          state_q;
  logic [15:0]       w_q, h_q, wbx_q, wby_q;
  logic [2:0]        nb_q;
  logic              staged_q, err_q, wb_q;
  logic [31:0]       data_q;

  logic [2:0]        nb;
  logic              is_copy, is_empty, bad, staged;
  logic [ADDR_W-1:0] src_base, dst_base, src_addr, dst_addr;
  logic [15:0]       ps, pd, wb_x, wb_y;
  logic [IDX_W-1:0]  idx;
  logic              last, wk_load, wk_rewind, wk_step, rd_back, wr_take;
  logic [31:0]       stage_rd;

  blit_setup #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .BUF_PIX(BUF_PIX)) u_setup (
    .fmt_i, .rop_i, .x_fwd_i, .y_fwd_i, .sep_i,
    .src_x_i, .src_y_i, .dst_x_i, .dst_y_i, .width_i, .height_i,
    .src_pitch_i, .dst_pitch_i, .def_pitch_i, .src_off_i, .dst_off_i, .def_off_i,
    .nbytes_o(nb), .is_copy_o(is_copy), .is_empty_o(is_empty), .bad_o(bad),
    .staged_o(staged), .src_base_o(src_base), .dst_base_o(dst_base),
    .src_pitch_o(ps), .dst_pitch_o(pd), .wb_x_o(wb_x), .wb_y_o(wb_y)
  );

  assign rd_back   = (state_q == ST_RD_WAIT) && mem_rvalid_i;
  assign wr_take   = (state_q == ST_WR_REQ) && mem_ready_i;
  assign wk_load   = (state_q == ST_IDLE) && start_i;
  assign wk_rewind = rd_back && staged_q && last;
  assign wk_step   = (rd_back && staged_q && !last) || (wr_take && !last);

  blit_walker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_walk (
    .clk_i, .rst_ni,
    .load_i(wk_load), .rewind_i(wk_rewind), .step_i(wk_step),
    .width_i(w_q), .height_i(h_q), .nbytes_i(nb_q),
    .src_pitch_i(ps), .dst_pitch_i(pd), .src_base_i(src_base), .dst_base_i(dst_base),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr), .idx_o(idx), .last_o(last)
  );

  blit_stage_buf #(.DW(32), .DEPTH(BUF_PIX)) u_stage (
    .clk_i,
    .we_i(rd_back && staged_q), .waddr_i(idx), .wdata_i(mem_rdata_i),
    .raddr_i(idx), .rdata_o(stage_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      w_q      <= '0;
      h_q      <= '0;
      nb_q     <= '0;
      staged_q <= 1'b0;
      err_q    <= 1'b0;
      wb_q     <= 1'b0;
      wbx_q    <= '0;
      wby_q    <= '0;
      data_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          w_q      <= width_i;
          h_q      <= height_i;
          nb_q     <= nb;
          staged_q <= staged;
          wbx_q    <= wb_x;
          wby_q    <= wb_y;
          if (!is_copy || is_empty) begin
            err_q   <= 1'b0;
            wb_q    <= 1'b0;
            state_q <= ST_FIN;
          end else if (bad) begin
            err_q   <= 1'b1;
            wb_q    <= 1'b0;
            state_q <= ST_FIN;
          end else begin
            err_q   <= 1'b0;
            wb_q    <= 1'b1;
            state_q <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: if (mem_ready_i) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rvalid_i) begin
          data_q  <= mem_rdata_i;
          // staged mode keeps reading until the whole rectangle is held
          state_q <= (!staged_q || last) ? ST_WR_REQ : ST_RD_REQ;
        end
        ST_WR_REQ: if (mem_ready_i) begin
          if (last)           state_q <= ST_FIN;
          else if (!staged_q) state_q <= ST_RD_REQ;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid_o = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_we_o    = (state_q == ST_WR_REQ);
  assign mem_addr_o  = mem_we_o ? dst_addr : src_addr;
  assign mem_size_o  = nb_q;
  assign mem_wdata_o = staged_q ? stage_rd : data_q;

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);
  assign err_o      = done_o && err_q;
  assign wb_valid_o = done_o && wb_q;
  assign dst_x_wb_o = wbx_q;
  assign dst_y_wb_o = wby_q;
endmodule

// File: rtl/blit_copy_checker.sv
module blit_copy_checker #(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 65536
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [2:0]        mem_size_o,
  input logic [31:0]       mem_wdata_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              wb_valid_o
);
  localparam int AW1 = ADDR_W + 2;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R10
  AST_WB_ONLY_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (done_o && !err_o)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o))); // R11
  AST_SIZE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_size_o >= 3'd1 && mem_size_o <= 3'd4)); // R1
  AST_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> ((AW1'(mem_addr_o) + AW1'(mem_size_o)) <= AW1'(MEM_BYTES))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_valid_o); // R2
endmodule

bind blit_copy_engine blit_copy_checker #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o),
  .mem_wdata_o(mem_wdata_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .wb_valid_o(wb_valid_o)
);

// File: tb/sim_blit_copy_engine.sv
`timescale 1ns/1ps
module sim_blit_copy_engine;
  localparam int MEMB = 4096;
  localparam int AW   = 12;
  localparam int BUFP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start = 1'b0;
  logic [3:0]    fmt;
  logic [7:0]    rop;
  logic          xf, yf, sep;
  logic [15:0]   sx, sy, dx, dy, w, h, sp, dp, defp;
  logic [AW-1:0] so, dso, defo;
  logic          mvalid, mready, mwe, rvalid, busy, done, err, wbv;
  logic [AW-1:0] maddr;
  logic [2:0]    msize;
  logic [31:0]   wdata, rdata;
  logic [15:0]   wbx, wby;

  blit_copy_engine #(.MEM_BYTES(MEMB), .BUF_PIX(BUFP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fmt_i(fmt), .rop_i(rop),
    .x_fwd_i(xf), .y_fwd_i(yf), .sep_i(sep),
    .src_x_i(sx), .src_y_i(sy), .dst_x_i(dx), .dst_y_i(dy), .width_i(w), .height_i(h),
    .src_pitch_i(sp), .dst_pitch_i(dp), .def_pitch_i(defp),
    .src_off_i(so), .dst_off_i(dso), .def_off_i(defo),
    .mem_valid_o(mvalid), .mem_ready_i(mready), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_size_o(msize), .mem_wdata_o(wdata), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .err_o(err), .wb_valid_o(wbv),
    .dst_x_wb_o(wbx), .dst_y_wb_o(wby)
  );

  logic [7:0] mem  [MEMB];
  logic [7:0] snap [MEMB];
  logic [7:0] expm [MEMB];
  int n_tests = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, late_rd = 0, size_bad = 0, done_cnt = 0;
  int wr_base = 0;
  int exp_nb = 0;
  logic [7:0] lfsr = 8'hA5;
  bit finished = 0;

  always @(negedge clk) begin
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mready <= lfsr[0] | lfsr[2];
  end

  always @(posedge clk) begin
    rvalid <= 1'b0;
    if (mvalid && mready) begin
      if (mwe) begin
        for (int b = 0; b < 4; b++)
          if (b < int'(msize)) mem[(int'(maddr) + b) % MEMB] <= wdata[8*b +: 8];
        wr_cnt <= wr_cnt + 1;
        if (int'(msize) != exp_nb) size_bad <= size_bad + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
        if (wr_cnt != wr_base) late_rd <= late_rd + 1;
        if (int'(msize) != exp_nb) size_bad <= size_bad + 1;
        rvalid <= 1'b1;
        rdata  <= '0;
        for (int b = 0; b < 4; b++)
          if (b < int'(msize)) rdata[8*b +: 8] <= mem[(int'(maddr) + b) % MEMB];
      end
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int nbytes_of(input int code);
    case (code)
      2: return 1;
      3, 4: return 2;
      5: return 3;
      6: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic init_mem(input int seed);
    for (int i = 0; i < MEMB; i++) mem[i] = 8'((i * 13 + seed * 7 + (i >> 8)) & 255);
  endtask

  task automatic set_default();
    fmt = 4'd2; rop = 8'hCC; xf = 1; yf = 1; sep = 1;
    sx = 2; sy = 1; dx = 20; dy = 10; w = 3; h = 2;
    sp = 64; dp = 64; defp = 64; so = 0; dso = 0; defo = 0;
  endtask

  int ewbx, ewby;
  task automatic model();
    int nb = nbytes_of(int'(fmt));
    int csx = xf ? int'(sx) : int'(sx) + 1 - int'(w);
    int csy = yf ? int'(sy) : int'(sy) + 1 - int'(h);
    int cdx = xf ? int'(dx) : int'(dx) + 1 - int'(w);
    int cdy = yf ? int'(dy) : int'(dy) + 1 - int'(h);
    int ps = sep ? int'(sp) : int'(defp);
    int pd = sep ? int'(dp) : int'(defp);
    int os = sep ? int'(so) : int'(defo);
    int od = sep ? int'(dso) : int'(defo);
    for (int i = 0; i < MEMB; i++) expm[i] = mem[i];
    for (int r = 0; r < int'(h); r++)
      for (int c = 0; c < int'(w); c++)
        for (int b = 0; b < nb; b++)
          expm[od + (cdy + r) * pd + (cdx + c) * nb + b] = mem[os + (csy + r) * ps + (csx + c) * nb + b];
    ewbx = xf ? cdx + int'(w) : cdx;
    ewby = yf ? cdy + int'(h) : cdy;
    exp_nb = nb;
  endtask

  logic got_err, got_wbv;
  logic [15:0] got_wbx, got_wby;
  int d_rd, d_wr, d_late, d_size, d_done, post_traffic;

  // mode 0: single pulse, 1: start held through done, 2: extra pulse mid-run
  task automatic go(input int mode);
    int rd0 = rd_cnt, wr0 = wr_cnt, late0 = late_rd, sz0 = size_bad, dn0 = done_cnt;
    int tr_at_done;
    bit seen = 0;
    for (int i = 0; i < MEMB; i++) snap[i] = mem[i];
    wr_base = wr_cnt;
    @(negedge clk) start = 1'b1;
    if (mode != 1) @(negedge clk) start = 1'b0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      if (done) begin
        seen = 1;
        got_err = err; got_wbv = wbv; got_wbx = wbx; got_wby = wby;
      end else begin
        if (mode == 2 && k == 2) start = 1'b1;
        if (mode == 2 && k == 3) start = 1'b0;
        @(negedge clk);
      end
    end
    check(seen, "R10 done seen", seen, 1);
    if (mode == 1) @(negedge clk) start = 1'b0;
    tr_at_done = rd_cnt + wr_cnt;
    repeat (12) @(negedge clk);
    post_traffic = rd_cnt + wr_cnt - tr_at_done;
    d_rd = rd_cnt - rd0; d_wr = wr_cnt - wr0; d_late = late_rd - late0;
    d_size = size_bad - sz0; d_done = done_cnt - dn0;
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < MEMB; i++) if (mem[i] !== expm[i]) n++;
    return n;
  endfunction

  task automatic run_ok(input string req, input int mode);
    int md;
    model();
    go(mode);
    md = mem_diff();
    check(!got_err, req, got_err, 0);
    check(md == 0, req, md, 0);
    check(got_wbv && int'(got_wbx) == ewbx && int'(got_wby) == ewby, {req, " R9 wb"},
          {got_wbx, got_wby}, {16'(ewbx), 16'(ewby)});
    check(d_size == 0, {req, " R1 size"}, d_size, 0);
    check(d_done == 1, {req, " R10 one done"}, d_done, 1);
  endtask

  task automatic run_err(input string req);
    int md;
    for (int i = 0; i < MEMB; i++) expm[i] = mem[i];
    go(0);
    md = mem_diff();
    check(got_err === 1'b1, req, got_err, 1);
    check(d_wr == 0 && md == 0 && !got_wbv, {req, " no write"}, d_wr + md, 0);
  endtask

  task automatic run_nop(input string req);
    go(0);
    check(!got_err && !got_wbv, req, {got_err, got_wbv}, 0);
    check(d_rd + d_wr == 0, {req, " no traffic"}, d_rd + d_wr, 0);
  endtask

  initial begin
    mready = 1'b0;
    rvalid = 1'b0;
    rdata  = '0;
    set_default();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mvalid && !err && !wbv, "R10 reset idle",
          {busy, done, mvalid, err, wbv}, 0);

    // R1: every format code
    for (int f = 0; f < 16; f++) begin
      set_default(); fmt = 4'(f);
      init_mem(f);
      if (nbytes_of(f) != 0) run_ok($sformatf("R1 fmt=%0d", f), 0);
      else run_err($sformatf("R1 bad fmt=%0d", f));
    end

    // R3 R4 R8: directions x pitch select x formats
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 2; s++)
        for (int fi = 0; fi < 3; fi++) begin
          set_default();
          fmt = (fi == 0) ? 4'd2 : (fi == 1) ? 4'd5 : 4'd6;
          xf = d[0]; yf = d[1]; sep = s[0];
          sx = 6; sy = 4; w = 4; h = 3;
          if (xf && yf) begin dx = 20; dy = 12; end
          else begin dx = 7; dy = 5; end
          so = 12'd8; dso = 12'd8; sp = 48; dp = 48;
          defo = 12'd100; defp = 64;
          if (!s[0]) begin so = 12'd999; dso = 12'd777; sp = 16; dp = 16; end
          init_mem(d * 8 + s * 3 + fi);
          run_ok($sformatf("R3 R4 dir=%0d sep=%0d fmt=%0d", d, s, fmt), 0);
          if (!(xf && yf)) check(d_late == 0, "R8 reads before writes", d_late, 0);
        end

    // R2: other raster codes
    for (int r = 0; r < 6; r++) begin
      set_default();
      rop = (r == 0) ? 8'h00 : (r == 1) ? 8'hF0 : (r == 2) ? 8'h33 :
            (r == 3) ? 8'hCB : (r == 4) ? 8'hCD : 8'hFF;
      run_nop($sformatf("R2 rop=%0h", rop));
    end

    // R5: coordinate limit
    set_default(); dx = 16'h4000; run_err("R5 dst x over limit");
    set_default(); sy = 16'h4000; run_err("R5 src y over limit");
    set_default(); xf = 0; dx = 1; w = 3; run_err("R5 dst wraps below zero");
    set_default(); yf = 0; sy = 0; h = 2; run_err("R5 src wraps below zero");

    // R6: end of frame memory
    set_default(); dy = 63; dx = 60; w = 4; h = 1; init_mem(40); run_ok("R6 ends at limit", 0);
    set_default(); dy = 63; dx = 60; w = 5; h = 1; run_err("R6 one byte past");
    set_default(); sy = 62; sx = 60; w = 5; h = 2; run_err("R6 source past");

    // R7: zero pitch
    set_default(); sp = 0; run_err("R7 src pitch zero");
    set_default(); dp = 0; run_err("R7 dst pitch zero");
    set_default(); sep = 0; defp = 0; run_err("R7 shared pitch zero");
    set_default(); defp = 0; init_mem(41); run_ok("R7 unused shared pitch zero", 0);

    // R8: staging capacity
    set_default(); xf = 0; sx = 12; sy = 2; dx = 13; dy = 3; w = 8; h = 8;
    init_mem(42); run_ok("R8 area at capacity", 0);
    check(d_late == 0, "R8 capacity reads first", d_late, 0);
    set_default(); yf = 0; sx = 20; sy = 10; dx = 21; dy = 11; w = 13; h = 5;
    run_err("R8 area over capacity");

    // R12: empty rectangle
    set_default(); w = 0; run_nop("R12 zero width");
    set_default(); h = 0; run_nop("R12 zero height");

    // R10: start during run and during done cycle
    set_default(); init_mem(43); run_ok("R10 start held", 1);
    check(post_traffic == 0, "R10 held start ignored", post_traffic, 0);
    set_default(); init_mem(44); run_ok("R10 start mid-run", 2);
    check(post_traffic == 0, "R10 mid-run start ignored", post_traffic, 0);

    // R11 is watched by the bound checker under the random ready pattern
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule